// File: doc/BRIEF.md
# Serial Flash Status and Write-Enable Unit

This block keeps the status byte of a serial NOR flash controller. An instruction decoder sends it single-cycle strobes: set the write-enable latch, clear it, write the status byte with a data byte, and start a byte program, an auto-increment (AAI) word program or an erase. The array sequencer reports the end of each internal operation on a done strobe, and it raises a top-address flag together with done when an AAI sequence has written the last location.

The unit decides which strobes are accepted. It tracks the busy state and the latch. It holds the three block-protect bits and the lock that freezes them. It drives the status byte for read-out, a flag that says a new memory write would be accepted, and the protect level for the address-protection logic that follows it. All state is volatile and returns to the fully protected default on every reset.

Top module: `flash_status_unit`

## Requirements
- R1: The status byte maps bit 0 to busy, bit 1 to the write-enable latch, bits 4:2 to the protect level (bit 2 is its LSB), bit 5 always 0, bit 6 to AAI mode and bit 7 to the protect lock. `prot_level_o` equals status bits 4:2.
- R2: After reset the status byte reads 8'h1C: busy, latch, AAI mode and lock are 0, and the protect level is 3'b111.
- R3: A write-enable strobe sets the latch. A write-disable strobe clears it. If both arrive in the same cycle, the disable wins.
- R4: A status write is accepted only while the latch is 1. It loads the lock from data bit 7 and the protect level from data bits 4:2, ignores data bits 6, 5, 1 and 0, and clears the latch. The new value is visible one cycle after the strobe.
- R5: While the lock is 1, a status write leaves the protect level unchanged but still loads the lock from data bit 7.
- R6: An accepted program, AAI or erase start sets busy one cycle after the strobe. Busy stays 1 until the sequencer's done strobe, and reads 0 one cycle after done.
- R7: Completion of a byte program or an erase clears the latch on the same cycle that busy clears.
- R8: While the latch is 0, start strobes are rejected and busy stays 0. `wr_permit_o` is 1 only when the latch is 1 and busy is 0.
- R9: An accepted AAI start sets AAI mode. A word completion without the top-address flag keeps the latch and the mode. Completion with the flag, or a write-disable while AAI mode is idle, clears the mode and the latch on the same cycle.
- R10: While busy is 1, all write-enable, write-disable, status-write and start strobes are ignored. The status byte stays readable.
- R11: In AAI mode, status writes, byte-program starts and erase starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen_set_i | input | 1 | Write-enable instruction strobe |
| wen_clr_i | input | 1 | Write-disable instruction strobe |
| sw_i | input | 1 | Status-write instruction strobe |
| sw_data_i | input | 8 | Data byte of the status write |
| byte_pgm_i | input | 1 | Byte-program start strobe |
| aai_pgm_i | input | 1 | AAI word-program start strobe |
| erase_i | input | 1 | Sector, block or chip erase start strobe |
| seq_done_i | input | 1 | Sequencer done strobe for the internal operation |
| aai_top_i | input | 1 | Highest address reached, qualified by done |
| status_o | output | 8 | Status byte |
| wr_permit_o | output | 1 | A memory write would be accepted now |
| prot_level_o | output | 3 | Block-protect level |

## Verification
Every state change is held in a register, so each result shows up exactly one clock after the edge that samples its strobe or done pulse. The bench drives strobes just after a rising edge. It advances a behavioural model on the next rising edge and compares the whole output set at the following falling edge. Directed checks use the same one-cycle rule. For the multi-cycle busy window they sample while the operation is still running and again just after done.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int BP_W   = 3;
  localparam int STAT_W = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BP0  = 2;
  localparam int BIT_RSV  = BIT_BP0 + BP_W;
  localparam int BIT_AAI  = 6;
  localparam int BIT_LOCK = 7;
  localparam logic [BP_W-1:0] BP_RESET = '1;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_BYTE  = 2'd1,
    OP_ERASE = 2'd2,
    OP_AAI   = 2'd3
  } op_e;
endpackage

// File: rtl/fsr_busy_trk.sv
module fsr_busy_trk
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  op_e  op_i,
  input  logic done_i,
  output logic busy_o,
  output op_e  op_o,
  output logic cmpl_o
);
  logic busy_q, busy_d;
  op_e  op_q, op_d;

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    if (busy_q && done_i) begin
      busy_d = 1'b0;
      op_d   = OP_NONE;
    end else if (!busy_q && start_i) begin
      busy_d = 1'b1;
      op_d   = op_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign cmpl_o = busy_q & done_i;

  // R6: busy rises only after a start strobe
  p_busy_from_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i));
  // R6: busy holds until done
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> busy_q);
  // R6: busy drops one cycle after done
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> !busy_q);
endmodule

// File: rtl/fsr_prot_reg.sv
module fsr_prot_reg
  import fsr_pkg::*;
#(
  parameter int W = BP_W
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] bp_i,
  input  logic         lock_i,
  output logic [W-1:0] bp_o,
  output logic         lock_o
);
  logic [W-1:0] bp_q, bp_d;
  logic         lock_q, lock_d;
  logic         bp_en;

  assign bp_en = wr_i & ~lock_q;

  always_comb begin
    bp_d   = bp_q;
    lock_d = lock_q;
    if (bp_en) bp_d   = bp_i;
    if (wr_i)  lock_d = lock_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= {W{1'b1}};
      lock_q <= 1'b0;
    end else begin
      bp_q   <= bp_d;
      lock_q <= lock_d;
    end
  end

  assign bp_o   = bp_q;
  assign lock_o = lock_q;

  // R5: protect level frozen while locked
  p_bp_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (bp_q == $past(bp_q)));
  // R4: nothing changes without an accepted write
  p_no_write_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(bp_q) && $stable(lock_q)));
endmodule

// File: rtl/fsr_wel_ctrl.sv
module fsr_wel_ctrl
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic sw_i,
  input  logic aai_enter_i,
  input  logic cmpl_i,
  input  op_e  cmpl_op_i,
  input  logic top_i,
  output logic wel_o,
  output logic aai_o
);
  logic wel_q, wel_d;
  logic aai_q, aai_d;
  logic aai_end;
  logic plain_end;

  assign aai_end   = cmpl_i & (cmpl_op_i == OP_AAI) & top_i;
  assign plain_end = cmpl_i & (cmpl_op_i != OP_AAI);

  always_comb begin
    wel_d = wel_q;
    aai_d = aai_q;
    if (clr_i) begin
      wel_d = 1'b0;
      aai_d = 1'b0;
    end else if (set_i) begin
      wel_d = 1'b1;
    end else if (sw_i || plain_end) begin
      wel_d = 1'b0;
    end else if (aai_end) begin
      wel_d = 1'b0;
      aai_d = 1'b0;
    end
    if (aai_enter_i) aai_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      aai_q <= 1'b0;
    end else begin
      wel_q <= wel_d;
      aai_q <= aai_d;
    end
  end

  assign wel_o = wel_q;
  assign aai_o = aai_q;

  // R9: AAI mode never outlives the latch
  p_aai_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aai_q |-> wel_q);
  // R7: byte program or erase completion drops the latch
  p_cmpl_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    plain_end |=> !wel_q);
  // R4: accepted status write drops the latch
  p_sw_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_i |=> !wel_q);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wen_set_i,
  input  logic       wen_clr_i,
  input  logic       sw_i,
  input  logic [7:0] sw_data_i,
  input  logic       byte_pgm_i,
  input  logic       aai_pgm_i,
  input  logic       erase_i,
  input  logic       seq_done_i,
  input  logic       aai_top_i,
  output logic [7:0] status_o,
  output logic       wr_permit_o,
  output logic [2:0] prot_level_o
);
  logic          busy, wel, aai, lock, cmpl;
  logic [BP_W-1:0] bp;
  op_e           cur_op, start_op;
  logic          idle, other_cmd;
  logic          acc_clr, acc_set, acc_sw, acc_erase, acc_byte, acc_aai, acc_start;

  assign idle      = ~busy;
  assign other_cmd = wen_clr_i | wen_set_i;

  assign acc_clr   = idle & wen_clr_i;
  assign acc_set   = idle & wen_set_i & ~wen_clr_i;
  assign acc_sw    = idle & wel & ~aai & sw_i & ~other_cmd;
  assign acc_erase = idle & wel & ~aai & erase_i & ~other_cmd & ~sw_i;
  assign acc_byte  = idle & wel & ~aai & byte_pgm_i & ~other_cmd & ~sw_i & ~erase_i;
  assign acc_aai   = idle & wel & aai_pgm_i & ~other_cmd & ~sw_i & ~erase_i & ~byte_pgm_i;
  assign acc_start = acc_erase | acc_byte | acc_aai;

  always_comb begin
    start_op = OP_NONE;
    if (acc_erase)     start_op = OP_ERASE;
    else if (acc_byte) start_op = OP_BYTE;
    else if (acc_aai)  start_op = OP_AAI;
  end

  fsr_busy_trk u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (acc_start),
    .op_i    (start_op),
    .done_i  (seq_done_i),
    .busy_o  (busy),
    .op_o    (cur_op),
    .cmpl_o  (cmpl)
  );

  fsr_prot_reg #(.W(BP_W)) u_prot (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (acc_sw),
    .bp_i   (sw_data_i[BIT_BP0 +: BP_W]),
    .lock_i (sw_data_i[BIT_LOCK]),
    .bp_o   (bp),
    .lock_o (lock)
  );

  fsr_wel_ctrl u_wel (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (acc_set),
    .clr_i       (acc_clr),
    .sw_i        (acc_sw),
    .aai_enter_i (acc_aai),
    .cmpl_i      (cmpl),
    .cmpl_op_i   (cur_op),
    .top_i       (aai_top_i),
    .wel_o       (wel),
    .aai_o       (aai)
  );

  always_comb begin
    status_o                      = '0;
    status_o[BIT_BUSY]            = busy;
    status_o[BIT_WEL]             = wel;
    status_o[BIT_BP0 +: BP_W]     = bp;
    status_o[BIT_RSV]             = 1'b0;
    status_o[BIT_AAI]             = aai;
    status_o[BIT_LOCK]            = lock;
  end

  assign wr_permit_o  = wel & ~busy;
  assign prot_level_o = bp;

  // R8: no operation starts without the latch
  p_reject_no_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel && !busy) |=> !busy);
  // R10: latch and mode hold while busy and not finishing
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done_i) |=> ($stable(wel) && $stable(aai) && $stable(bp) && $stable(lock)));
  // R11: in AAI mode the protect state is untouched
  p_aai_no_sw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    aai |=> ($stable(bp) && $stable(lock)));
  // R9: leaving AAI mode clears latch on the same cycle
  p_aai_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai) |-> !wel);
  // R1: reserved bit reads zero
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[BIT_RSV] == 1'b0);
endmodule

// File: tb/test_flash_status_unit.sv
module test_flash_status_unit;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wen_set_i = 0, wen_clr_i = 0, sw_i = 0;
  logic [7:0] sw_data_i = '0;
  logic       byte_pgm_i = 0, aai_pgm_i = 0, erase_i = 0;
  logic       seq_done_i = 0, aai_top_i = 0;
  logic [7:0] status_o;
  logic       wr_permit_o;
  logic [2:0] prot_level_o;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;

  always #(CLK_PER/2) clk = ~clk;

  flash_status_unit i_flash_status_unit (
    .clk(clk), .rst_n(rst_n),
    .wen_set_i(wen_set_i), .wen_clr_i(wen_clr_i),
    .sw_i(sw_i), .sw_data_i(sw_data_i),
    .byte_pgm_i(byte_pgm_i), .aai_pgm_i(aai_pgm_i), .erase_i(erase_i),
    .seq_done_i(seq_done_i), .aai_top_i(aai_top_i),
    .status_o(status_o), .wr_permit_o(wr_permit_o), .prot_level_o(prot_level_o)
  );

  // behavioural reference state
  bit m_busy, m_wel, m_aai, m_lock;
  int m_bp;
  int m_op; // 0 none, 1 byte, 2 erase, 3 aai

  function automatic logic [7:0] m_status();
    return {m_lock, m_aai, 1'b0, m_bp[2:0], m_wel, m_busy};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wel = 0; m_aai = 0; m_lock = 0; m_bp = 7; m_op = 0;
    end else if (m_busy) begin
      if (seq_done_i) begin
        m_busy = 0;
        if (m_op != 3) m_wel = 0;
        else if (aai_top_i) begin m_wel = 0; m_aai = 0; end
        m_op = 0;
      end
    end else if (wen_clr_i) begin
      m_wel = 0; m_aai = 0;
    end else if (wen_set_i) begin
      m_wel = 1;
    end else if (m_wel) begin
      if (sw_i) begin
        if (!m_aai) begin
          if (!m_lock) m_bp = int'(sw_data_i[4:2]);
          m_lock = sw_data_i[7];
          m_wel = 0;
        end
      end else if (erase_i) begin
        if (!m_aai) begin m_busy = 1; m_op = 2; end
      end else if (byte_pgm_i) begin
        if (!m_aai) begin m_busy = 1; m_op = 1; end
      end else if (aai_pgm_i) begin
        m_busy = 1; m_op = 3; m_aai = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model (R1 layout, R8 permit)
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      check(status_o == m_status(), "R1 status", status_o, m_status());
      check(prot_level_o == m_bp[2:0], "R1 prot_level", {5'b0, prot_level_o}, 8'(m_bp));
      check(wr_permit_o == (m_wel && !m_busy), "R8 wr_permit", {7'b0, wr_permit_o}, {7'b0, m_wel && !m_busy});
    end
  end

  task automatic idle_cycle();
    @(posedge clk); #1;
  endtask

  // pulse a strobe for one cycle; result is visible after the next edge
  task automatic strobe(input int which, input logic [7:0] data = 8'h00, input bit top = 0);
    @(posedge clk); #1;
    case (which)
      0: wen_set_i = 1;
      1: wen_clr_i = 1;
      2: begin sw_i = 1; sw_data_i = data; end
      3: byte_pgm_i = 1;
      4: aai_pgm_i = 1;
      5: erase_i = 1;
      6: begin seq_done_i = 1; aai_top_i = top; end
      default: ;
    endcase
    @(posedge clk); #1;
    wen_set_i = 0; wen_clr_i = 0; sw_i = 0; byte_pgm_i = 0;
    aai_pgm_i = 0; erase_i = 0; seq_done_i = 0; aai_top_i = 0; sw_data_i = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle_cycle();
    // R2: reset state
    check(status_o == 8'h1C, "R2 reset status", status_o, 8'h1C);
    check(prot_level_o == 3'b111, "R1 reset prot_level", {5'b0, prot_level_o}, 8'h07);

    // R8: start without latch rejected
    strobe(5);
    check(status_o[0] == 0, "R8 erase rejected", status_o, 8'h1C);
    strobe(3);
    check(status_o[0] == 0, "R8 program rejected", status_o, 8'h1C);

    // R3: set and clear latch, disable wins when both
    strobe(0);
    check(status_o[1] == 1, "R3 wel set", status_o, 8'h1E);
    check(wr_permit_o == 1, "R8 permit with wel", {7'b0, wr_permit_o}, 8'h01);
    strobe(1);
    check(status_o[1] == 0, "R3 wel cleared", status_o, 8'h1C);
    @(posedge clk); #1; wen_set_i = 1; wen_clr_i = 1;
    @(posedge clk); #1; wen_set_i = 0; wen_clr_i = 0;
    check(status_o[1] == 0, "R3 disable wins", status_o, 8'h1C);

    // R4: status write without latch ignored
    strobe(2, 8'h80);
    check(status_o == 8'h1C, "R4 write needs wel", status_o, 8'h1C);
    // R4: status write changes only lock and protect level, clears latch
    strobe(0);
    strobe(2, 8'hE3);
    check(status_o == 8'h80, "R4 masked write", status_o, 8'h80);

    // R5: locked protect level frozen, lock still writable
    strobe(0);
    strobe(2, 8'h1C);
    check(status_o == 8'h00, "R5 bp frozen lock cleared", status_o, 8'h00);
    strobe(0);
    strobe(2, 8'h94);
    check(status_o == 8'h94, "R5 bp and lock loaded", status_o, 8'h94);
    strobe(0);
    strobe(2, 8'h08);
    check(prot_level_o == 3'b101, "R5 bp kept under lock", {5'b0, prot_level_o}, 8'h05);
    check(status_o[7] == 0, "R5 lock written to 0", status_o, 8'h14);

    // R6/R10: erase busy window
    strobe(0);
    strobe(5);
    check(status_o[0] == 1, "R6 busy after erase start", status_o, 8'h17);
    strobe(1);
    check(status_o[1] == 1, "R10 disable ignored while busy", status_o, 8'h17);
    strobe(2, 8'h80);
    check(status_o[7] == 0, "R10 status write ignored while busy", status_o, 8'h17);
    check(wr_permit_o == 0, "R8 permit low while busy", {7'b0, wr_permit_o}, 8'h00);
    idle_cycle();
    check(status_o[0] == 1, "R6 busy held", status_o, 8'h17);
    // R7: erase completion clears busy and latch together
    strobe(6);
    check(status_o[1:0] == 2'b00, "R7 erase done", status_o, 8'h14);

    // R7: byte program completion
    strobe(0);
    strobe(3);
    check(status_o[0] == 1, "R6 busy after program", status_o, 8'h17);
    strobe(6);
    check(status_o[1:0] == 2'b00, "R7 program done", status_o, 8'h14);

    // R9: AAI sequence to the top address
    strobe(0);
    strobe(4);
    check(status_o[6] == 1 && status_o[0] == 1, "R9 aai entered", status_o, 8'h57);
    strobe(6);
    check(status_o[6] == 1 && status_o[1] == 1, "R9 aai word keeps wel", status_o, 8'h56);
    // R11: in AAI mode status write, program and erase ignored
    strobe(2, 8'h80);
    check(status_o[7] == 0 && status_o[1] == 1, "R11 status write ignored", status_o, 8'h56);
    strobe(5);
    check(status_o[0] == 0, "R11 erase ignored", status_o, 8'h56);
    strobe(3);
    check(status_o[0] == 0, "R11 program ignored", status_o, 8'h56);
    strobe(4);
    strobe(6, 8'h00, 1);
    check(status_o[6] == 0 && status_o[1] == 0, "R9 top address exit", status_o, 8'h14);

    // R9: explicit exit by write disable
    strobe(0);
    strobe(4);
    strobe(6);
    strobe(1);
    check(status_o[6] == 0 && status_o[1] == 0, "R9 disable exit", status_o, 8'h14);

    // R2: reset again restores defaults
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    idle_cycle();
    check(status_o == 8'h1C, "R2 re-reset status", status_o, 8'h1C);

    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule